// File: doc/BRIEF.md
# Clock Output Power-Mode Controller

This block sits between a free-running oscillator and a clock output pin and decides when that output may be driven. One external enable pin and a static configuration word select whether the output runs or sits in one of three disable depths. The shallowest depth only turns off the output driver. The middle depth also stops the oscillator. The deepest depth also removes power from the core, and only the configuration retention stays alive.

The block oversamples the oscillator level on its own system clock. It turns the output driver off or on only at a falling edge of the oscillator. A high pulse is therefore never cut short. After re-enable, the first driven edge is a clean rising edge that follows a full low phase.

Leaving the middle or deepest depth first powers the needed domains. It then waits a per-mode number of ticks of an always-on slow tick before it arms the output. While a disable, settle or arm sequence is in progress, the pin is not looked at.

Top module: `clkpm_ctrl`

## Requirements
- R1: While reset is asserted, clk_oe_o and clk_o are 0, and osc_en_o and core_en_o are 1. After reset the block waits for the first oscillator falling edge and then starts driving.
- R2: The enable pin passes through a two-stage synchronizer. A level present before rising edge k is acted on at rising edge k+2.
- R3: cfg_i[2] selects polarity: 0 means pin high runs and pin low disables, and 1 is the inverse. cfg_i[1:0] selects the disable depth: 00 stop, 01 doze, 10 sleep, 11 stop.
- R4: clk_oe_o changes only on the clock edge at which the registered oscillator level goes from 1 to 0. On disable, the last high pulse keeps its full width.
- R5: While disabled, clk_oe_o is 0 in all three depths. The power enables are: stop gives osc_en_o=1 and core_en_o=1, doze gives osc_en_o=0 and core_en_o=1, sleep gives both 0. The output is never enabled while either power enable is low.
- R6: Resume from stop uses no settle wait. The output is enabled at the next oscillator falling edge after the synchronized pin asks to run.
- R7: Resume from doze raises osc_en_o at once. It then waits DOZE_TICKS slow_tick_i pulses before waiting for a falling edge.
- R8: Resume from sleep raises osc_en_o and core_en_o at once. It then waits SLEEP_TICKS slow_tick_i pulses before waiting for a falling edge.
- R9: Pin changes are ignored while a disable, settle or arm sequence is in progress. Such a sequence always runs to its end.
- R10: clk_o follows the registered oscillator level only while clk_oe_o is 1, and is 0 otherwise. Every complete high or low pulse while enabled lasts at least half an oscillator period.
- R11: The disable depth is captured when the disable starts. Changing cfg_i[1:0] while disabled does not change the resume sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin_i | input | 1 | Asynchronous enable pin level |
| cfg_i | input | 3 | Bit 2 is the polarity; bits 1:0 are the disable depth |
| osc_i | input | 1 | Oscillator level, synchronous to clk |
| slow_tick_i | input | 1 | One-cycle pulse from the always-on slow time base |
| clk_o | output | 1 | Gated output clock level |
| clk_oe_o | output | 1 | Output driver enable; 0 means high impedance |
| osc_en_o | output | 1 | Oscillator and resonator power enable |
| core_en_o | output | 1 | Core power domain enable |

## Verification
A wrong internal state first shows up on the power enables or on clk_oe_o. A mode latched wrongly or a skipped settle wait gives an early osc_en_o or core_en_o level, or an early clk_oe_o rise. The per-cycle reference comparison catches these on the first cycle they differ, which is within one oscillator period of the pin change. A gate that switches off the falling edge leaves a short pulse on clk_o, which the pulse-width monitor reports when that pulse ends.

// File: rtl/clkpm_pkg.sv
`timescale 1ns/1ps
package clkpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_OFF    = 3'd2,
    ST_SETTLE = 3'd3,
    ST_ARM    = 3'd4
  } pm_state_e;

  typedef enum logic [1:0] {
    MD_STOP  = 2'd0,
    MD_DOZE  = 2'd1,
    MD_SLEEP = 2'd2
  } pm_mode_e;

  // Depth field decode; the unused code falls back to the shallowest depth.
  function automatic pm_mode_e decode_depth(input logic [1:0] field);
    case (field)
      2'd1:    decode_depth = MD_DOZE;
      2'd2:    decode_depth = MD_SLEEP;
      default: decode_depth = MD_STOP;
    endcase
  endfunction

endpackage

// File: rtl/clkpm_sync.sv
`timescale 1ns/1ps
module clkpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= d_i;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/clkpm_settle_timer.sv
`timescale 1ns/1ps
module clkpm_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (tick_i && (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && !load_i) |=> (cnt_q == '0)); // R7

  AST_TIMER_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!load_i) && (cnt_q != $past(cnt_q))) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R8

endmodule

// File: rtl/clkpm_out_gate.sv
`timescale 1ns/1ps
module clkpm_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_i,
  input  logic oe_set_i,
  input  logic oe_clr_i,
  output logic osc_fall_o,
  output logic oe_o,
  output logic clk_o
);

  logic osc_q;
  logic oe_q, oe_d;

  // A falling edge seen on the incoming sample; the gate may only move here.
  assign osc_fall_o = osc_q && !osc_i;

  always_comb begin
    oe_d = oe_q;
    if (oe_clr_i)      oe_d = 1'b0;
    else if (oe_set_i) oe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      osc_q <= osc_i;
      oe_q  <= oe_d;
    end
  end

  assign oe_o  = oe_q;
  assign clk_o = osc_q && oe_q;

  AST_GATE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> ($past(osc_q) && !osc_q)); // R4

  AST_NO_SET_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_set_i && oe_clr_i)); // R4

endmodule

// File: rtl/clkpm_mode_fsm.sv
`timescale 1ns/1ps
module clkpm_mode_fsm
  import clkpm_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DOZE_TICKS  = 80,
  parameter int SLEEP_TICKS = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_s_i,
  input  logic             pol_i,
  input  logic [1:0]       depth_i,
  input  logic             osc_fall_i,
  input  logic             oe_i,
  input  logic             expired_i,
  output logic             oe_set_o,
  output logic             oe_clr_o,
  output logic             ld_o,
  output logic [CNT_W-1:0] ld_val_o,
  output logic             osc_en_o,
  output logic             core_en_o
);

  localparam logic [CNT_W-1:0] DOZE_LD  = CNT_W'(DOZE_TICKS);
  localparam logic [CNT_W-1:0] SLEEP_LD = CNT_W'(SLEEP_TICKS);

  pm_state_e state_q, state_d;
  pm_mode_e  mode_q, mode_d;
  logic      osc_en_q, osc_en_d;
  logic      core_en_q, core_en_d;
  logic      want_run;

  assign want_run = pin_s_i ^ pol_i;

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    osc_en_d  = osc_en_q;
    core_en_d = core_en_q;
    oe_set_o  = 1'b0;
    oe_clr_o  = 1'b0;
    ld_o      = 1'b0;
    ld_val_o  = (mode_q == MD_DOZE) ? DOZE_LD : SLEEP_LD;
    case (state_q)
      ST_RUN: begin
        if (!want_run) begin
          mode_d  = decode_depth(depth_i);
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (osc_fall_i) begin
          oe_clr_o  = 1'b1;
          osc_en_d  = (mode_q == MD_STOP);
          core_en_d = (mode_q != MD_SLEEP);
          state_d   = ST_OFF;
        end
      end
      ST_OFF: begin
        if (want_run) begin
          osc_en_d  = 1'b1;
          core_en_d = 1'b1;
          if (mode_q == MD_STOP) begin
            state_d = ST_ARM;
          end else begin
            ld_o    = 1'b1;
            state_d = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: begin
        if (expired_i) state_d = ST_ARM;
      end
      ST_ARM: begin
        if (osc_fall_i) begin
          oe_set_o = 1'b1;
          state_d  = ST_RUN;
        end
      end
      default: state_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_ARM;
      mode_q    <= MD_STOP;
      osc_en_q  <= 1'b1;
      core_en_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      mode_q    <= mode_d;
      osc_en_q  <= osc_en_d;
      core_en_q <= core_en_d;
    end
  end

  assign osc_en_o  = osc_en_q;
  assign core_en_o = core_en_q;

  AST_CORE_BEFORE_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en_q |-> !osc_en_q); // R5

  AST_DRIVE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    oe_i |-> (osc_en_q && core_en_q)); // R5

  AST_STOP_SKIPS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |-> (mode_q != MD_STOP)); // R6

  AST_DRAIN_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |=> (state_q == ST_DRAIN || state_q == ST_OFF)); // R9

  AST_SETTLE_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |=> (state_q == ST_SETTLE || state_q == ST_ARM)); // R9

  AST_MODE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |=> $stable(mode_q)); // R11

endmodule

// File: rtl/clkpm_ctrl.sv
`timescale 1ns/1ps
module clkpm_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DOZE_TICKS  = 80,
  parameter int SLEEP_TICKS = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin_i,
  input  logic [2:0] cfg_i,
  input  logic       osc_i,
  input  logic       slow_tick_i,
  output logic       clk_o,
  output logic       clk_oe_o,
  output logic       osc_en_o,
  output logic       core_en_o
);

  localparam int MAX_TICKS = (DOZE_TICKS > SLEEP_TICKS) ? DOZE_TICKS : SLEEP_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             pin_s;
  logic             osc_fall;
  logic             oe;
  logic             oe_set, oe_clr;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             expired;

  clkpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (en_pin_i),
    .q_o   (pin_s)
  );

  clkpm_mode_fsm #(
    .CNT_W       (CNT_W),
    .DOZE_TICKS  (DOZE_TICKS),
    .SLEEP_TICKS (SLEEP_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_s_i    (pin_s),
    .pol_i      (cfg_i[2]),
    .depth_i    (cfg_i[1:0]),
    .osc_fall_i (osc_fall),
    .oe_i       (oe),
    .expired_i  (expired),
    .oe_set_o   (oe_set),
    .oe_clr_o   (oe_clr),
    .ld_o       (ld),
    .ld_val_o   (ld_val),
    .osc_en_o   (osc_en_o),
    .core_en_o  (core_en_o)
  );

  clkpm_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ld),
    .load_val_i (ld_val),
    .tick_i     (slow_tick_i),
    .expired_o  (expired)
  );

  clkpm_out_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_i      (osc_i),
    .oe_set_i   (oe_set),
    .oe_clr_i   (oe_clr),
    .osc_fall_o (osc_fall),
    .oe_o       (oe),
    .clk_o      (clk_o)
  );

  assign clk_oe_o = oe;

  AST_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_oe_o |-> !clk_o); // R10

  AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en_o |-> (!clk_oe_o && !osc_en_o)); // R5

endmodule

// File: tb/clkpm_ctrl_test.sv
`timescale 1ns/1ps
module clkpm_ctrl_test;

  localparam int OSC_HALF = 3;
  localparam int SLOW_DIV = 4;
  localparam int DOZE_T   = 5;
  localparam int SLEEP_T  = 9;
  localparam int WD_LIMIT = 150000;

  logic       clk;
  logic       rst_n;
  logic       en_pin;
  logic [2:0] cfg;
  logic       osc;
  logic       slow_tick;
  logic       clk_o, clk_oe_o, osc_en_o, core_en_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int tdiv   = 0;
  int ph     = 0;

  // reference model state
  int m_s1, m_s2, m_oscq, m_st, m_oe, m_osc_en, m_core_en, m_mode, m_left;

  // pulse monitor
  int pw_lvl, pw_len, prev_oe;

  clkpm_ctrl #(.SYNC_STAGES(2), .DOZE_TICKS(DOZE_T), .SLEEP_TICKS(SLEEP_T)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_pin_i    (en_pin),
    .cfg_i       (cfg),
    .osc_i       (osc),
    .slow_tick_i (slow_tick),
    .clk_o       (clk_o),
    .clk_oe_o    (clk_oe_o),
    .osc_en_o    (osc_en_o),
    .core_en_o   (core_en_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Behavioural reference: modes as small integers, run=0 drain=1 off=2 settle=3 arm=4
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_oscq = 0; m_st = 4; m_oe = 0;
      m_osc_en = 1; m_core_en = 1; m_mode = 0; m_left = 0;
    end else begin
      int want, fall;
      want = (m_s2 != int'(cfg[2])) ? 1 : 0;
      fall = (m_oscq == 1 && osc == 1'b0) ? 1 : 0;
      case (m_st)
        0: if (want == 0) begin
             m_mode = (cfg[1:0] == 2'd3) ? 0 : int'(cfg[1:0]);
             m_st = 1;
           end
        1: if (fall == 1) begin
             m_oe = 0;
             m_osc_en  = (m_mode == 0) ? 1 : 0;
             m_core_en = (m_mode == 2) ? 0 : 1;
             m_st = 2;
           end
        2: if (want == 1) begin
             m_osc_en = 1; m_core_en = 1;
             if (m_mode == 0) m_st = 4;
             else begin
               m_left = (m_mode == 1) ? DOZE_T : SLEEP_T;
               m_st = 3;
             end
           end
        3: if (m_left == 0) m_st = 4;
           else if (slow_tick) m_left--;
        default: if (fall == 1) begin m_oe = 1; m_st = 0; end
      endcase
      m_s2 = m_s1;
      m_s1 = int'(en_pin);
      m_oscq = int'(osc);
    end
  end

  task automatic cycle();
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      chk(int'(clk_oe_o) == m_oe, "R4 clk_oe_o", int'(clk_oe_o), m_oe);
      chk(int'(osc_en_o) == m_osc_en, "R5 osc_en_o", int'(osc_en_o), m_osc_en);
      chk(int'(core_en_o) == m_core_en, "R5 core_en_o", int'(core_en_o), m_core_en);
      chk(int'(clk_o) == (m_oscq & m_oe), "R10 clk_o", int'(clk_o), m_oscq & m_oe);
      // R10: complete pulses while enabled keep at least half a period
      if (clk_oe_o) begin
        if (prev_oe == 0) begin
          pw_lvl = int'(clk_o); pw_len = 1;
        end else if (int'(clk_o) == pw_lvl) begin
          pw_len++;
        end else begin
          chk(pw_len >= OSC_HALF, "R10 pulse width", pw_len, OSC_HALF);
          pw_lvl = int'(clk_o); pw_len = 1;
        end
      end
      prev_oe = int'(clk_oe_o);
    end
    // oscillator model follows the expected power enable
    if (m_osc_en == 0) begin
      osc = 1'b0; ph = 0;
    end else begin
      ph++;
      if (ph == OSC_HALF) begin ph = 0; osc = ~osc; end
    end
    tdiv++;
    slow_tick = (tdiv % SLOW_DIV == 0);
    if (cyc > WD_LIMIT) begin
      chk(1'b0, "watchdog", cyc, WD_LIMIT);
      finish_run();
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wait_oe(input int limit, output int lat);
    lat = 0;
    do begin cycle(); lat++; end while (!clk_oe_o && lat < limit);
  endtask

  // One full disable / resume pass for a given polarity and depth code
  task automatic pass(input bit pol, input logic [1:0] dcode);
    int lat, depth;
    logic run_lvl;
    depth   = (dcode == 2'd3) ? 0 : int'(dcode);
    run_lvl = ~pol;
    cfg     = {pol, dcode};
    en_pin  = run_lvl;
    run(30);
    chk(clk_oe_o == 1'b1, "R3 running at run level", int'(clk_oe_o), 1);
    en_pin = ~run_lvl;
    run(30);
    chk(clk_oe_o == 1'b0, "R3 disabled at inverse level", int'(clk_oe_o), 0);
    chk(int'(osc_en_o) == ((depth == 0) ? 1 : 0), "R5 osc power in depth", int'(osc_en_o), (depth == 0) ? 1 : 0);
    chk(int'(core_en_o) == ((depth == 2) ? 0 : 1), "R5 core power in depth", int'(core_en_o), (depth == 2) ? 0 : 1);
    en_pin = run_lvl;
    wait_oe(400, lat);
    if (depth == 0)
      chk(lat <= 3 + 2 * OSC_HALF + 2, "R6 stop resume latency", lat, 3 + 2 * OSC_HALF + 2);
    else if (depth == 1)
      chk(lat >= (DOZE_T - 1) * SLOW_DIV && lat <= (DOZE_T + 1) * SLOW_DIV + 14,
          "R7 doze resume latency", lat, DOZE_T * SLOW_DIV);
    else
      chk(lat >= (SLEEP_T - 1) * SLOW_DIV && lat <= (SLEEP_T + 1) * SLOW_DIV + 14,
          "R8 sleep resume latency", lat, SLEEP_T * SLOW_DIV);
    run(30);
  endtask

  initial begin
    int lat, seen;
    rst_n = 1'b0; en_pin = 1'b1; cfg = 3'b000; osc = 1'b0; slow_tick = 1'b0;
    prev_oe = 0; pw_lvl = 0; pw_len = 0;
    run(4);
    // R1 reset values
    chk(clk_oe_o == 1'b0, "R1 clk_oe_o in reset", int'(clk_oe_o), 0);
    chk(clk_o == 1'b0, "R1 clk_o in reset", int'(clk_o), 0);
    chk(osc_en_o == 1'b1, "R1 osc_en_o in reset", int'(osc_en_o), 1);
    chk(core_en_o == 1'b1, "R1 core_en_o in reset", int'(core_en_o), 1);
    rst_n = 1'b1;
    wait_oe(40, lat);
    chk(clk_oe_o == 1'b1, "R1 drive after reset", int'(clk_oe_o), 1);

    // R2 R3: every polarity and depth code, compared to the model each cycle
    for (int p = 0; p < 2; p++)
      for (int d = 0; d < 4; d++)
        pass(p[0], d[1:0]);

    // R9: pin drops back during the doze settle wait; sequence still completes
    cfg = 3'b001; en_pin = 1'b0;
    run(30);
    en_pin = 1'b1;
    run(8);
    en_pin = 1'b0;
    seen = 0;
    for (int i = 0; i < 120; i++) begin
      cycle();
      if (clk_oe_o) seen = 1;
    end
    chk(seen == 1, "R9 settle not aborted", seen, 1);
    chk(clk_oe_o == 1'b0, "R9 then disabled again", int'(clk_oe_o), 0);

    // R9: short run pulse during the drain window is ignored
    en_pin = 1'b1;
    run(60);
    en_pin = 1'b0;
    run(3);
    en_pin = 1'b1;
    run(1);
    en_pin = 1'b0;
    run(40);
    chk(clk_oe_o == 1'b0, "R9 drain pulse ignored", int'(clk_oe_o), 0);
    chk(osc_en_o == 1'b0, "R9 doze reached", int'(osc_en_o), 0);

    // R11: enter sleep, then switch the depth field to stop before resuming
    en_pin = 1'b1;
    run(80);
    cfg = 3'b010; en_pin = 1'b0;
    run(30);
    cfg = 3'b000;
    run(5);
    chk(core_en_o == 1'b0, "R11 still in sleep after cfg change", int'(core_en_o), 0);
    en_pin = 1'b1;
    wait_oe(400, lat);
    chk(lat >= (SLEEP_T - 1) * SLOW_DIV, "R11 latched sleep resume", lat, SLEEP_T * SLOW_DIV);
    run(30);

    finish_run();
  end

endmodule